// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers thirty peripheral interrupt lines and seven software-raised requests, one per level, and reduces them to one 3-bit level and one 8-bit vector number for a processor core. Every source has a fixed level and a fixed rank inside that level. The core supplies a 3-bit mask. Levels 1 to 6 compete only when they lie strictly above the mask. Level 7 always competes. Two selector registers can lift any peripheral source into the two highest slots of level 6, above every fixed source at that level.

Software reaches the block through a 64-byte register window at the top of a 24-bit byte-addressed bus. The window holds byte-wide controls that raise and drop the software requests, the two remap selectors, and an acknowledge read that returns the vector of the current winner. A service routine can therefore dispatch without a hardware acknowledge cycle. A separate combinational output can restart the clocks during a low-power state as soon as any request above the mask appears.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `lvl_o` and `vec_o` are 0, all software requests are clear, both remap selectors read 0, and `wake_o` is low with no request present.
- R2: Peripheral line i (bit i of `irq_req_i`) has level 6 - i/5 and rank 6 - i%5. The software request of level L has rank 0 at level L. The winner is the eligible source with the highest level, and among sources of that level, the highest rank.
- R3: A source of level 1 to 6 is eligible only when its level is greater than `mask_i`. A level-7 source is eligible at every mask value.
- R4: The vector equals 62 plus a legacy number. The legacy number is 2+i for peripheral line i and 31+L for the software request of level L. `lvl_o`/`vec_o` are registered. They show the winner of the inputs present at the previous clock edge, and they are both 0 when no source is eligible.
- R5: A byte write to offset 0x18 with value v in 0..6 raises the software request of level v+1. Other values change nothing and return no error.
- R6: A byte write to offset 0x19 with value v in 0..6 drops the software request of level v+1. Other values change nothing.
- R7: The remap selectors sit at offsets 0x10 (first) and 0x11 (second) and are read/write. A value n in 1..30 moves line n-1 out of its fixed slot. The first selector places it at level 6, rank 8. The second places it at level 6, rank 7. The value 0 or any value above 30 leaves every line in its fixed slot.
- R8: A byte read of offset 0x20 returns the vector of the source that wins under the current mask, or 0 when no source is eligible.
- R9: `wake_o` is high exactly when `lp_en_i` is high and at least one eligible source is asserted. The path has no clocked element.
- R10: Every access gets `bus_ack` one cycle after `bus_sel`. The access also gets `bus_err` and reads 0 when any of these holds: the address is outside the window (bits 23:6 not all ones); the offset is unimplemented; the size code is not byte (size 2'b00); it is a write to 0x20; it is a read of 0x18 or 0x19. An access that ends in error changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 30 | Peripheral request lines, active high |
| mask_i | input | 3 | Current interrupt mask from the core |
| lp_en_i | input | 1 | Enables the wake-up path during low power |
| lvl_o | output | 3 | Registered level of the winning request |
| vec_o | output | 8 | Registered vector of the winning request |
| wake_o | output | 1 | Combinational wake-up request |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code, 2'b00 = byte |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_ack | output | 1 | Access response, one cycle after the strobe |
| bus_err | output | 1 | Error termination |
| bus_rdata | output | 8 | Read data |

## Verification
The hardest case to reach is a source that competes from two places at once. This happens when both remap selectors name the same line, or when a remapped line sits next to a fixed source at the same level and the mask sits right at 5 or 6. The random stimulus writes the remap selectors with values drawn from a small band around the valid range, so duplicates, zero and out-of-range numbers all occur. It also draws mask values from the full range while peripheral lines are sparse. Directed cases then set up a remap winner over a fixed level-6 source, the removal of that winner, and a level-7 software request under mask 7.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int N_PERIPH_DEF = 30;
  localparam int N_LVL        = 7;
  localparam int LVL_W        = 3;
  localparam int RANK_W       = 4;
  localparam int VEC_W        = 8;
  localparam int GROUP        = 5;
  localparam int VEC_BASE     = 62;
  localparam int SW_LEGACY    = 31;
  localparam int PER_LEGACY   = 2;
  localparam int REMAP_LVL    = 6;
  localparam int REMAP1_RANK  = 8;
  localparam int REMAP2_RANK  = 7;
  localparam int SW_RANK      = 0;

  localparam logic [5:0] OFS_REMAP1 = 6'h10;
  localparam logic [5:0] OFS_REMAP2 = 6'h11;
  localparam logic [5:0] OFS_SWSET  = 6'h18;
  localparam logic [5:0] OFS_SWCLR  = 6'h19;
  localparam logic [5:0] OFS_ACK    = 6'h20;

  localparam logic [1:0] SIZE_BYTE  = 2'b00;

  typedef struct packed {
    logic [LVL_W-1:0]  lvl;
    logic [RANK_W-1:0] rank;
    logic [VEC_W-1:0]  vec;
  } irq_cand_t;

  function automatic logic [LVL_W-1:0] per_level(input int idx);
    return LVL_W'(REMAP_LVL - idx / GROUP);
  endfunction

  function automatic logic [RANK_W-1:0] per_rank(input int idx);
    return RANK_W'(6 - idx % GROUP);
  endfunction

  function automatic logic [VEC_W-1:0] per_vec(input int idx);
    return VEC_W'(VEC_BASE + PER_LEGACY + idx);
  endfunction

  function automatic logic [VEC_W-1:0] sw_vec(input int lvl);
    return VEC_W'(VEC_BASE + SW_LEGACY + lvl);
  endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int N_PERIPH = N_PERIPH_DEF
) (
  input  logic [N_PERIPH-1:0] req_i,
  input  logic [N_LVL-1:0]    sw_req_i,
  input  logic [LVL_W-1:0]    mask_i,
  input  logic [7:0]          remap1_i,
  input  logic [7:0]          remap2_i,
  output logic [LVL_W-1:0]    win_lvl_o,
  output logic [VEC_W-1:0]    win_vec_o,
  output logic                hit_o
);

  localparam int N_SRC = N_PERIPH + N_LVL;

  irq_cand_t        cand [N_SRC];
  logic [N_SRC-1:0] elig;

  // Peripheral candidates: fixed slot unless a selector lifts the line
  for (genvar g = 0; g < N_PERIPH; g++) begin : g_per
    logic sel1, sel2;
    assign sel1 = (remap1_i == 8'(g + 1));
    assign sel2 = (remap2_i == 8'(g + 1));
    always_comb begin
      cand[g].vec = per_vec(g);
      if (sel1) begin
        cand[g].lvl  = LVL_W'(REMAP_LVL);
        cand[g].rank = RANK_W'(REMAP1_RANK);
      end else if (sel2) begin
        cand[g].lvl  = LVL_W'(REMAP_LVL);
        cand[g].rank = RANK_W'(REMAP2_RANK);
      end else begin
        cand[g].lvl  = per_level(g);
        cand[g].rank = per_rank(g);
      end
    end
    assign elig[g] = req_i[g] &&
                     ((cand[g].lvl == LVL_W'(N_LVL)) || (cand[g].lvl > mask_i));
  end

  // Software candidates: one per level, lowest rank in the level
  for (genvar l = 0; l < N_LVL; l++) begin : g_sw
    assign cand[N_PERIPH+l].lvl  = LVL_W'(l + 1);
    assign cand[N_PERIPH+l].rank = RANK_W'(SW_RANK);
    assign cand[N_PERIPH+l].vec  = sw_vec(l + 1);
    assign elig[N_PERIPH+l] = sw_req_i[l] &&
                              ((l + 1 == N_LVL) || (LVL_W'(l + 1) > mask_i));
  end

  // Linear maximum search over {level, rank}
  always_comb begin
    logic [LVL_W+RANK_W-1:0] best_key;
    logic                    found;
    best_key  = '0;
    found     = 1'b0;
    win_lvl_o = '0;
    win_vec_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!found || ({cand[i].lvl, cand[i].rank} > best_key))) begin
        found     = 1'b1;
        best_key  = {cand[i].lvl, cand[i].rank};
        win_lvl_o = cand[i].lvl;
        win_vec_o = cand[i].vec;
      end
    end
  end

  assign hit_o = |elig;

  always_comb begin
    assert (hit_o == (win_lvl_o != '0))
      else $error("AST_HIT_LEVEL"); // R4
  end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_prio_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic [VEC_W-1:0]  win_vec_i,
  output logic [N_LVL-1:0]  sw_req_o,
  output logic [7:0]        remap1_o,
  output logic [7:0]        remap2_o,
  output logic              bus_ack,
  output logic              bus_err,
  output logic [7:0]        bus_rdata
);

  logic [5:0]       ofs;
  logic             in_win;
  logic             bad;
  logic             good_wr;
  logic [7:0]       rd_mux;
  logic [N_LVL-1:0] sw_d;
  logic [7:0]       remap1_d, remap2_d;
  logic             sw_en, remap1_en, remap2_en;
  logic             ack_d, err_d;
  logic [7:0]       rdata_d;

  assign ofs    = bus_addr[5:0];
  assign in_win = &bus_addr[ADDR_W-1:6];

  // Decode
  always_comb begin
    bad    = 1'b0;
    rd_mux = '0;
    unique case (ofs)
      OFS_REMAP1: rd_mux = remap1_o;
      OFS_REMAP2: rd_mux = remap2_o;
      OFS_SWSET,
      OFS_SWCLR:  bad = !bus_wr;
      OFS_ACK:    begin
                    bad    = bus_wr;
                    rd_mux = win_vec_i;
                  end
      default:    bad = 1'b1;
    endcase
    if (!in_win || (bus_size != SIZE_BYTE)) bad = 1'b1;
  end

  assign good_wr = bus_sel && bus_wr && !bad;

  // Next state
  always_comb begin
    sw_d      = sw_req_o;
    sw_en     = 1'b0;
    remap1_d  = bus_wdata;
    remap2_d  = bus_wdata;
    remap1_en = good_wr && (ofs == OFS_REMAP1);
    remap2_en = good_wr && (ofs == OFS_REMAP2);
    if (good_wr && (bus_wdata < 8'(N_LVL))) begin
      if (ofs == OFS_SWSET) begin
        sw_en = 1'b1;
        sw_d[bus_wdata[2:0]] = 1'b1;
      end else if (ofs == OFS_SWCLR) begin
        sw_en = 1'b1;
        sw_d[bus_wdata[2:0]] = 1'b0;
      end
    end
    ack_d   = bus_sel;
    err_d   = bus_sel && bad;
    rdata_d = (bus_sel && !bus_wr && !bad) ? rd_mux : 8'h00;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_req_o  <= '0;
      remap1_o  <= '0;
      remap2_o  <= '0;
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (sw_en)     sw_req_o <= sw_d;
      if (remap1_en) remap1_o <= remap1_d;
      if (remap2_en) remap2_o <= remap2_d;
      bus_ack   <= ack_d;
      bus_err   <= err_d;
      bus_rdata <= rdata_d;
    end
  end

  AST_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && (bus_size != SIZE_BYTE)) |=> (bus_err && bus_ack)); // R10

  AST_OUT_WIN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !(&bus_addr[ADDR_W-1:6])) |=> (bus_err && bus_rdata == 8'h00)); // R10

  AST_ACK_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && in_win && bus_size == SIZE_BYTE && ofs == OFS_ACK)
      |=> (bus_rdata == $past(win_vec_i))); // R8

  AST_SET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && ofs == OFS_SWSET && bus_wdata > 8'd6) |=> $stable(sw_req_o)); // R5

  AST_REMAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> ($stable(remap1_o) && $stable(remap2_o))); // R7

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N_PERIPH = N_PERIPH_DEF,
  parameter int ADDR_W   = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_PERIPH-1:0] irq_req_i,
  input  logic [LVL_W-1:0]    mask_i,
  input  logic                lp_en_i,
  output logic [LVL_W-1:0]    lvl_o,
  output logic [VEC_W-1:0]    vec_o,
  output logic                wake_o,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [1:0]          bus_size,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [7:0]          bus_wdata,
  output logic                bus_ack,
  output logic                bus_err,
  output logic [7:0]          bus_rdata
);

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic [N_LVL-1:0] sw_req;
  logic [7:0]       remap1, remap2;
  logic [LVL_W-1:0] win_lvl;
  logic [VEC_W-1:0] win_vec;
  logic             hit;

  irq_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .win_vec_i (win_vec),
    .sw_req_o  (sw_req),
    .remap1_o  (remap1),
    .remap2_o  (remap2),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata)
  );

  irq_arbiter #(.N_PERIPH(N_PERIPH)) arb_i (
    .req_i     (irq_req_i),
    .sw_req_i  (sw_req),
    .mask_i    (mask_i),
    .remap1_i  (remap1),
    .remap2_i  (remap2),
    .win_lvl_o (win_lvl),
    .win_vec_o (win_vec),
    .hit_o     (hit)
  );

  // Wake-up path: purely combinational
  assign wake_o = lp_en_i & hit;

  // Output registers with explicit enable
  logic             out_en;
  logic [LVL_W-1:0] lvl_d;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    lvl_d  = win_lvl;
    vec_d  = win_vec;
    out_en = (lvl_d != lvl_o) || (vec_d != vec_o);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      lvl_o <= '0;
      vec_o <= '0;
    end else if (out_en) begin
      lvl_o <= lvl_d;
      vec_o <= vec_d;
    end
  end

  AST_LVL_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_s_n)
    (lvl_o != '0) |-> ((lvl_o == LVL_W'(N_LVL)) || (lvl_o > $past(mask_i)))); // R3

  AST_ZERO_PAIR: assert property (@(posedge clk) disable iff (!rst_s_n)
    (lvl_o == '0) == (vec_o == '0)); // R4

  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_s_n)
    1'b1 |=> (vec_o == $past(win_vec))); // R4

endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;

  localparam int NP = 30;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [NP-1:0] irq_req_i;
  logic [2:0]  mask_i;
  logic        lp_en_i;
  logic [2:0]  lvl_o;
  logic [7:0]  vec_o;
  logic        wake_o;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_size;
  logic [23:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_ack, bus_err;
  logic [7:0]  bus_rdata;

  always #4 clk = ~clk; // 125 MHz

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .mask_i(mask_i),
    .lp_en_i(lp_en_i), .lvl_o(lvl_o), .vec_o(vec_o), .wake_o(wake_o),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [6:0] m_sw;
  logic [7:0] m_r1, m_r2;

  localparam logic [23:0] WIN = 24'hFFFFC0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: returns {level, vector}
  function automatic logic [10:0] ref_win(input logic [NP-1:0] rq, input logic [2:0] mk);
    int bl = 0, br = -1, bv = 0;
    for (int i = 0; i < NP + 7; i++) begin
      int l, r, v;
      bit a;
      if (i < NP) begin
        a = rq[i];
        v = 64 + i;
        if (m_r1 == 8'(i + 1)) begin l = 6; r = 8; end
        else if (m_r2 == 8'(i + 1)) begin l = 6; r = 7; end
        else begin l = 6 - i / 5; r = 6 - i % 5; end
      end else begin
        l = i - NP + 1; r = 0; v = 93 + l; a = m_sw[l-1];
      end
      if (a && (l == 7 || l > int'(mk)) && (l > bl || (l == bl && r > br))) begin
        bl = l; br = r; bv = v;
      end
    end
    return {3'(bl), 8'(bv)};
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic bus(input bit wr, input logic [1:0] sz, input logic [23:0] a,
                     input logic [7:0] d, output logic [7:0] rd, output bit er);
    bus_sel = 1'b1; bus_wr = wr; bus_size = sz; bus_addr = a; bus_wdata = d;
    tick();
    rd = bus_rdata; er = bus_err;
    chk("R10 ack", int'(bus_ack), 1);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr_ok(input logic [5:0] ofs, input logic [7:0] d);
    logic [7:0] rd; bit er;
    bus(1'b1, 2'b00, WIN | 24'(ofs), d, rd, er);
    chk("R10 no err", int'(er), 0);
    if (ofs == 6'h10) m_r1 = d;
    if (ofs == 6'h11) m_r2 = d;
    if (ofs == 6'h18 && d < 7) m_sw[d[2:0]] = 1'b1;
    if (ofs == 6'h19 && d < 7) m_sw[d[2:0]] = 1'b0;
    tick();
  endtask

  task automatic check_out(input string tag);
    logic [10:0] e;
    e = ref_win(irq_req_i, mask_i);
    chk({tag, " lvl"}, int'(lvl_o), int'(e[10:8]));
    chk({tag, " vec"}, int'(vec_o), int'(e[7:0]));
  endtask

  task automatic drive(input logic [NP-1:0] rq, input logic [2:0] mk);
    irq_req_i = rq; mask_i = mk;
    tick();
  endtask

  bit done = 0;

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    bit er;
    logic [10:0] e;
    void'($urandom(32'd2024));
    m_sw = '0; m_r1 = '0; m_r2 = '0;
    rst_n = 1'b0; irq_req_i = '0; mask_i = '0; lp_en_i = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_size = '0; bus_addr = '0; bus_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1: reset state
    chk("R1 lvl", int'(lvl_o), 0);
    chk("R1 vec", int'(vec_o), 0);
    chk("R1 wake", int'(wake_o), 0);
    bus(1'b0, 2'b00, WIN | 24'h10, 8'h00, rd, er);
    chk("R1 remap1", int'(rd), 0);
    bus(1'b0, 2'b00, WIN | 24'h20, 8'h00, rd, er);
    chk("R1 ack none", int'(rd), 0);

    // R2/R4: single and competing lines
    drive(30'h1, 3'd0);
    chk("R2 single lvl", int'(lvl_o), 6);
    chk("R4 single vec", int'(vec_o), 64);
    drive(30'h3, 3'd0);
    chk("R2 rank in level", int'(vec_o), 64);
    drive(30'h30, 3'd0);
    chk("R2 level first", int'(vec_o), 68);
    drive(30'h0, 3'd0);
    chk("R4 none lvl", int'(lvl_o), 0);

    // R3: masking
    drive(30'h1, 3'd6);
    chk("R3 masked", int'(lvl_o), 0);
    drive(30'h1, 3'd5);
    chk("R3 above mask", int'(lvl_o), 6);

    // R5/R6: software requests
    drive(30'h0, 3'd7);
    wr_ok(6'h18, 8'd6);
    chk("R5 set7 lvl", int'(lvl_o), 7);
    chk("R3 lvl7 unmaskable vec", int'(vec_o), 100);
    wr_ok(6'h19, 8'd7);
    chk("R6 clr ignored", int'(lvl_o), 7);
    wr_ok(6'h19, 8'd6);
    chk("R6 clr", int'(lvl_o), 0);
    drive(30'h0, 3'd0);
    wr_ok(6'h18, 8'd9);
    chk("R5 set ignored", int'(lvl_o), 0);
    wr_ok(6'h18, 8'd0);
    chk("R5 set lvl1 vec", int'(vec_o), 94);
    wr_ok(6'h19, 8'd0);

    // R7: remap
    wr_ok(6'h10, 8'd30);
    drive(30'h20000001, 3'd0);
    chk("R7 remap1 wins", int'(vec_o), 93);
    wr_ok(6'h11, 8'd25);
    drive(30'h21000001, 3'd0);
    chk("R7 remap1 over remap2", int'(vec_o), 93);
    drive(30'h01000001, 3'd0);
    chk("R7 remap2 over fixed", int'(vec_o), 88);
    drive(30'h20000000, 3'd5);
    chk("R7 remap lvl6 past mask5", int'(lvl_o), 6);
    wr_ok(6'h10, 8'd31);
    drive(30'h20000000, 3'd0);
    chk("R7 out of range", int'(lvl_o), 1);
    bus(1'b0, 2'b00, WIN | 24'h11, 8'h00, rd, er);
    chk("R7 read remap2", int'(rd), 25);

    // R8: acknowledge read
    irq_req_i = 30'h00000400; mask_i = 3'd0;
    bus(1'b0, 2'b00, WIN | 24'h20, 8'h00, rd, er);
    chk("R8 ack vec", int'(rd), 74);
    mask_i = 3'd4;
    bus(1'b0, 2'b00, WIN | 24'h20, 8'h00, rd, er);
    chk("R8 ack masked", int'(rd), 0);

    // R9: wake
    irq_req_i = 30'h1; mask_i = 3'd6; lp_en_i = 1'b1; #1;
    chk("R9 wake masked", int'(wake_o), 0);
    mask_i = 3'd5; #1;
    chk("R9 wake hit", int'(wake_o), 1);
    lp_en_i = 1'b0; #1;
    chk("R9 wake disabled", int'(wake_o), 0);
    tick();

    // R10: errors
    bus(1'b0, 2'b00, 24'h7FFFD0, 8'h00, rd, er);
    chk("R10 outside window", int'(er), 1);
    bus(1'b0, 2'b00, WIN | 24'h05, 8'h00, rd, er);
    chk("R10 unimplemented", int'(er), 1);
    bus(1'b1, 2'b01, WIN | 24'h10, 8'h07, rd, er);
    chk("R10 halfword", int'(er), 1);
    bus(1'b1, 2'b00, WIN | 24'h20, 8'h07, rd, er);
    chk("R10 write ack", int'(er), 1);
    bus(1'b0, 2'b00, WIN | 24'h18, 8'h00, rd, er);
    chk("R10 read set", int'(er), 1);
    chk("R10 rdata zero", int'(rd), 0);
    bus(1'b0, 2'b00, WIN | 24'h10, 8'h00, rd, er);
    chk("R10 err no write", int'(rd), 31);

    // Random phase
    for (int it = 0; it < 400; it++) begin
      logic [NP-1:0] rq;
      int op;
      rq = NP'($urandom) & NP'($urandom) & NP'($urandom);
      op = $urandom_range(0, 9);
      if (op == 0) wr_ok(6'h10, 8'($urandom_range(0, 33)));
      else if (op == 1) wr_ok(6'h11, 8'($urandom_range(0, 33)));
      else if (op == 2) wr_ok(6'h18, 8'($urandom_range(0, 8)));
      else if (op == 3) wr_ok(6'h19, 8'($urandom_range(0, 8)));
      drive(rq, 3'($urandom_range(0, 7)));
      check_out("R2 R3 random");
      e = ref_win(irq_req_i, mask_i);
      lp_en_i = 1'($urandom); #1;
      chk("R9 random wake", int'(wake_o), int'(lp_en_i && e[10:8] != 0));
      if (op == 4) begin
        bus(1'b0, 2'b00, WIN | 24'h20, 8'h00, rd, er);
        chk("R8 random ack", int'(rd), int'(e[7:0]));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule